// File: doc/BRIEF.md
# Indirect RAM Access Port

This block gives a host an 8-bit register window onto internal byte RAMs. There are three spaces behind the window: a sample RAM, and the low and high bytes of a connection memory. The host loads a nine-bit indirect address and a mode byte. The mode byte names the target space and holds two auto-increment enables. Each read or write of the data register then performs one RAM access at the current indirect address and current byte lane.

After each data access, the block moves its cursor. For the sample RAM, it adds one to the address when the enable for that access direction is set. For connection memory, it alternates between the low and high byte, and it advances the address only when the cursor returns from the high byte to the low byte. A whole connection memory can therefore be filled by streaming pairs of bytes.

The sequencer is a small state machine with five states:
- `ST_IDLE`: accepts host strobes.
- `ST_WR`: drives the RAM write strobe.
- `ST_RD`: drives the RAM read strobe.
- `ST_CAPT`: latches the returned byte.
- `ST_STEP`: moves the cursor.

Its transitions are:
- idle→write on a data-register write;
- idle→read on a data-register read;
- write→step;
- read→capture→step;
- step→idle.

Register accesses to the address and mode registers complete in `ST_IDLE` without leaving it.

Top module: `ind_access_port`

## Requirements
- R1: After reset, the address registers and the mode readback are all 0x00, and `h_busy` is low.
- R2: The register offsets are: 0 = address bits 7:0, 1 = address bit 8 (in data bit 0), 2 = mode, 3 = data. The address registers read back the current cursor address.
- R3: A data write produces exactly one `ram_wr` pulse carrying the current address, space and written byte. A data read produces one `ram_rd` pulse and returns the RAM byte on `h_rdata` with a one-cycle `h_rvalid`.
- R4: Mode bit 7 enables auto-increment after data writes, and mode bit 6 enables it after data reads. Each enable affects only its own direction.
- R5: In the sample space, an enabled access adds one to the address. A disabled access leaves the address unchanged.
- R6: Any data access in the connection-memory low space switches the lane to the high space and leaves the address unchanged, whatever the enables.
- R7: A data access in the connection-memory high space has two outcomes. With its enable set, the lane returns to low and the address advances. With its enable clear, the lane and the address stay as they are.
- R8: Mode bits 1:0 select the space: 0 is the sample RAM, 1 is connection-memory low, 2 is connection-memory high, and 3 is treated as the sample RAM. Writing the mode register sets the lane to that space. Mode readback bits 1:0 show the current lane.
- R9: When the address is above 383, a data write produces no `ram_wr`, and a data read produces no `ram_rd` and returns 0x00.
- R10: An address advance from 383 or above gives 0.
- R11: Host strobes that arrive while `h_busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_reg | input | 2 | Register offset |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte |
| h_rvalid | output | 1 | `h_rdata` is valid this cycle |
| h_busy | output | 1 | A data access is in progress |
| ram_addr | output | AW | RAM address (the cursor) |
| ram_space | output | 2 | Target space: 0 sample, 1 connection-memory low, 2 connection-memory high |
| ram_wr | output | 1 | RAM write strobe |
| ram_rd | output | 1 | RAM read strobe; data is expected on the next cycle |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte |

## Verification
Two things can happen in the same `ST_STEP` cycle: the lane flips from connection-memory high back to low, and the address wraps from 383 to 0. The bench provokes both together by placing the cursor at 383 in the high space, with auto-increment on write enabled, and then writing one byte. The result is judged through the normal interface. The byte must land at high-byte location 383. The address must read back as 0. The mode readback must show the low lane.

// File: rtl/ind_pkg.sv
package ind_pkg;

    typedef enum logic [1:0] {
        SP_SAMPLE = 2'd0,
        SP_CM_LO  = 2'd1,
        SP_CM_HI  = 2'd2
    } space_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WR   = 3'd1,
        ST_RD   = 3'd2,
        ST_CAPT = 3'd3,
        ST_STEP = 3'd4
    } seq_t;

    localparam logic [1:0] REG_ALO  = 2'd0;
    localparam logic [1:0] REG_AHI  = 2'd1;
    localparam logic [1:0] REG_MODE = 2'd2;
    localparam logic [1:0] REG_DATA = 2'd3;

    localparam int MODE_INC_RD = 6;
    localparam int MODE_INC_WR = 7;

    function automatic space_t to_space(input logic [1:0] code);
        space_t s;
        unique case (code)
            2'd1:    s = SP_CM_LO;
            2'd2:    s = SP_CM_HI;
            default: s = SP_SAMPLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ind_cursor.sv
module ind_cursor
    import ind_pkg::*;
#(
    parameter int AW   = 9,
    parameter int LAST = 383
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic          ld_mode,
    input  logic [7:0]    wbyte,
    input  logic          step,
    input  logic          inc_en,
    output logic [AW-1:0] addr,
    output space_t        lane
);

    localparam int            HW     = AW - 8;
    localparam logic [AW-1:0] LAST_A = AW'(LAST);
    localparam logic [AW-1:0] ONE_A  = AW'(1);

    logic [AW-1:0] addr_adv;

    always_comb begin
        if (addr >= LAST_A) begin
            addr_adv = '0;
        end else begin
            addr_adv = addr + ONE_A;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (ld_lo) begin
            addr[7:0] <= wbyte;
        end else if (ld_hi) begin
            addr[AW-1:8] <= wbyte[HW-1:0];
        end else if (step) begin
            unique case (lane)
                SP_SAMPLE: if (inc_en) addr <= addr_adv;
                SP_CM_LO:  addr <= addr;
                SP_CM_HI:  if (inc_en) addr <= addr_adv;
                default:   addr <= addr;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane <= SP_SAMPLE;
        end else if (ld_mode) begin
            lane <= to_space(wbyte[1:0]);
        end else if (step) begin
            unique case (lane)
                SP_SAMPLE: lane <= SP_SAMPLE;
                SP_CM_LO:  lane <= SP_CM_HI;
                SP_CM_HI:  if (inc_en) lane <= SP_CM_LO;
                default:   lane <= SP_SAMPLE;
            endcase
        end
    end

endmodule

// File: rtl/ind_seq.sv
module ind_seq
    import ind_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_rd,
    input  logic go_wr,
    input  logic in_range,
    output logic busy,
    output logic ram_wr,
    output logic ram_rd,
    output logic capt,
    output logic step,
    output logic step_rd
);

    seq_t state, state_nx;
    logic op_rd_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (go_wr)      state_nx = ST_WR;
                else if (go_rd) state_nx = ST_RD;
            end
            ST_WR:   state_nx = ST_STEP;
            ST_RD:   state_nx = ST_CAPT;
            ST_CAPT: state_nx = ST_STEP;
            ST_STEP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            op_rd_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && (go_wr || go_rd)) begin
                op_rd_q <= !go_wr;
            end
        end
    end

    always_comb begin
        busy    = 1'b1;
        ram_wr  = 1'b0;
        ram_rd  = 1'b0;
        capt    = 1'b0;
        step    = 1'b0;
        step_rd = op_rd_q;
        unique case (state)
            ST_IDLE: busy   = 1'b0;
            ST_WR:   ram_wr = in_range;
            ST_RD:   ram_rd = in_range;
            ST_CAPT: capt   = 1'b1;
            ST_STEP: step   = 1'b1;
            default: busy   = 1'b1;
        endcase
    end

endmodule

// File: rtl/ind_hostregs.sv
module ind_hostregs
    import ind_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_rd,
    input  logic          h_wr,
    input  logic [1:0]    h_reg,
    input  logic [7:0]    h_wdata,
    input  logic          busy,
    input  logic          capt,
    input  logic          in_range,
    input  logic [7:0]    ram_rdata,
    input  logic [AW-1:0] addr,
    input  space_t        lane,
    output logic          ld_lo,
    output logic          ld_hi,
    output logic          ld_mode,
    output logic          go_rd,
    output logic          go_wr,
    output logic [7:0]    mode_q,
    output logic [7:0]    wdata_q,
    output logic [7:0]    h_rdata,
    output logic          h_rvalid
);

    localparam int HW = AW - 8;

    logic       open;
    logic       reg_rd;
    logic [7:0] rb;
    logic [7:0] hi_rb;

    always_comb begin
        open    = !busy;
        ld_lo   = open && h_wr && (h_reg == REG_ALO);
        ld_hi   = open && h_wr && (h_reg == REG_AHI);
        ld_mode = open && h_wr && (h_reg == REG_MODE);
        go_wr   = open && h_wr && (h_reg == REG_DATA);
        go_rd   = open && h_rd && !h_wr && (h_reg == REG_DATA);
        reg_rd  = open && h_rd && !h_wr && (h_reg != REG_DATA);
    end

    always_comb begin
        hi_rb = '0;
        hi_rb[HW-1:0] = addr[AW-1:8];
        unique case (h_reg)
            REG_ALO:  rb = addr[7:0];
            REG_AHI:  rb = hi_rb;
            REG_MODE: rb = {mode_q[7:2], lane};
            default:  rb = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 8'h00;
            wdata_q <= 8'h00;
        end else begin
            if (ld_mode) mode_q  <= h_wdata;
            if (go_wr)   wdata_q <= h_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rdata  <= 8'h00;
            h_rvalid <= 1'b0;
        end else begin
            h_rvalid <= 1'b0;
            if (capt) begin
                h_rdata  <= in_range ? ram_rdata : 8'h00;
                h_rvalid <= 1'b1;
            end else if (reg_rd) begin
                h_rdata  <= rb;
                h_rvalid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ind_access_port.sv
module ind_access_port
    import ind_pkg::*;
#(
    parameter int AW   = 9,
    parameter int LAST = 383
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_rd,
    input  logic          h_wr,
    input  logic [1:0]    h_reg,
    input  logic [7:0]    h_wdata,
    output logic [7:0]    h_rdata,
    output logic          h_rvalid,
    output logic          h_busy,
    output logic [AW-1:0] ram_addr,
    output logic [1:0]    ram_space,
    output logic          ram_wr,
    output logic          ram_rd,
    output logic [7:0]    ram_wdata,
    input  logic [7:0]    ram_rdata
);

    localparam logic [AW-1:0] LAST_A = AW'(LAST);

    logic          ld_lo, ld_hi, ld_mode;
    logic          go_rd, go_wr;
    logic          capt, step, step_rd;
    logic          inc_en, in_range;
    logic [7:0]    mode_q, wdata_q;
    logic [AW-1:0] addr;
    space_t        lane;

    assign in_range  = (addr <= LAST_A);
    assign inc_en    = step_rd ? mode_q[MODE_INC_RD] : mode_q[MODE_INC_WR];
    assign ram_addr  = addr;
    assign ram_space = lane;
    assign ram_wdata = wdata_q;

    ind_hostregs #(.AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_rd     (h_rd),
        .h_wr     (h_wr),
        .h_reg    (h_reg),
        .h_wdata  (h_wdata),
        .busy     (h_busy),
        .capt     (capt),
        .in_range (in_range),
        .ram_rdata(ram_rdata),
        .addr     (addr),
        .lane     (lane),
        .ld_lo    (ld_lo),
        .ld_hi    (ld_hi),
        .ld_mode  (ld_mode),
        .go_rd    (go_rd),
        .go_wr    (go_wr),
        .mode_q   (mode_q),
        .wdata_q  (wdata_q),
        .h_rdata  (h_rdata),
        .h_rvalid (h_rvalid)
    );

    ind_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_rd   (go_rd),
        .go_wr   (go_wr),
        .in_range(in_range),
        .busy    (h_busy),
        .ram_wr  (ram_wr),
        .ram_rd  (ram_rd),
        .capt    (capt),
        .step    (step),
        .step_rd (step_rd)
    );

    ind_cursor #(.AW(AW), .LAST(LAST)) u_cursor (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_lo  (ld_lo),
        .ld_hi  (ld_hi),
        .ld_mode(ld_mode),
        .wbyte  (h_wdata),
        .step   (step),
        .inc_en (inc_en),
        .addr   (addr),
        .lane   (lane)
    );

endmodule

// File: rtl/ind_port_sva.sv
module ind_port_sva #(
    parameter int AW   = 9,
    parameter int LAST = 383
) (
    input logic          clk,
    input logic          rst_n,
    input logic          h_busy,
    input logic [AW-1:0] ram_addr,
    input logic [1:0]    ram_space,
    input logic          ram_wr,
    input logic          ram_rd
);

    localparam logic [AW-1:0] LAST_A = AW'(LAST);

    // R3: one write strobe per data write
    a_r3_single_wr: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |=> !ram_wr);

    // R9: no RAM write beyond the last location
    a_r9_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> (ram_addr <= LAST_A));

    // R9: no RAM read beyond the last location
    a_r9_rd_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd |-> (ram_addr <= LAST_A));

    // R6: a low-byte write moves to the high byte at the same address
    a_r6_lo_to_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_wr && ram_space == 2'd1) |-> ##2
        (ram_space == 2'd2 && ram_addr == $past(ram_addr, 2)));

    // R11: RAM strobes appear only inside a busy access
    a_r11_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_wr || ram_rd) |-> h_busy);

endmodule

bind ind_access_port ind_port_sva #(.AW(AW), .LAST(LAST)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_busy   (h_busy),
    .ram_addr (ram_addr),
    .ram_space(ram_space),
    .ram_wr   (ram_wr),
    .ram_rd   (ram_rd)
);

// File: tb/test_ind_access_port.sv
module test_ind_access_port;

    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          h_rd = 1'b0, h_wr = 1'b0;
    logic [1:0]    h_reg = 2'd0;
    logic [7:0]    h_wdata = 8'h00;
    logic [7:0]    h_rdata;
    logic          h_rvalid, h_busy;
    logic [AW-1:0] ram_addr;
    logic [1:0]    ram_space;
    logic          ram_wr, ram_rd;
    logic [7:0]    ram_wdata;
    logic [7:0]    ram_rdata = 8'h00;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    bit done = 0;

    logic [7:0] m_samp [512];
    logic [7:0] m_lo   [512];
    logic [7:0] m_hi   [512];

    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    ind_access_port #(.AW(AW), .LAST(383)) i_ind_access_port (
        .clk(clk), .rst_n(rst_n), .h_rd(h_rd), .h_wr(h_wr), .h_reg(h_reg),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid),
        .h_busy(h_busy), .ram_addr(ram_addr), .ram_space(ram_space),
        .ram_wr(ram_wr), .ram_rd(ram_rd), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    always @(posedge clk) begin
        if (ram_wr) begin
            wr_cnt <= wr_cnt + 1;
            case (ram_space)
                2'd1:    m_lo[ram_addr]   <= ram_wdata;
                2'd2:    m_hi[ram_addr]   <= ram_wdata;
                default: m_samp[ram_addr] <= ram_wdata;
            endcase
        end
        if (ram_rd) begin
            rd_cnt <= rd_cnt + 1;
            case (ram_space)
                2'd1:    ram_rdata <= m_lo[ram_addr];
                2'd2:    ram_rdata <= m_hi[ram_addr];
                default: ram_rdata <= m_samp[ram_addr];
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && h_rvalid) begin : mon
            exp_t e;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected h_rvalid", h_rdata, 0);
            end else begin
                e = exp_q.pop_front();
                chk(h_rdata == e.v, e.tag, h_rdata, e.v);
            end
        end
    end

    task automatic wait_idle();
        while (h_busy) @(negedge clk);
    endtask

    task automatic host_wr(input logic [1:0] r, input logic [7:0] d);
        wait_idle();
        h_reg = r; h_wdata = d; h_wr = 1'b1;
        @(negedge clk);
        h_wr = 1'b0;
        wait_idle();
    endtask

    task automatic host_rd(input logic [1:0] r, input logic [7:0] exp, input string tag);
        exp_t e;
        wait_idle();
        e.v = exp; e.tag = tag;
        exp_q.push_back(e);
        h_reg = r; h_rd = 1'b1;
        @(negedge clk);
        h_rd = 1'b0;
        wait_idle();
        @(negedge clk);
    endtask

    task automatic set_addr(input int a);
        host_wr(2'd0, a[7:0]);
        host_wr(2'd1, {7'd0, a[8]});
    endtask

    initial begin : wd
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(h_busy == 1'b0, "R1 busy after reset", h_busy, 0);
        host_rd(2'd0, 8'h00, "R1 addr low after reset");
        host_rd(2'd1, 8'h00, "R1 addr high after reset");
        host_rd(2'd2, 8'h00, "R1 mode after reset");

        // R2 R3 R5 sample write with increment on write
        set_addr(5);
        host_wr(2'd2, 8'h80);
        w0 = wr_cnt;
        host_wr(2'd3, 8'hA1);
        chk(wr_cnt == w0 + 1, "R3 one ram_wr per data write", wr_cnt - w0, 1);
        chk(m_samp[5] == 8'hA1, "R3 sample byte at 5", m_samp[5], 8'hA1);
        host_rd(2'd0, 8'h06, "R5 address advanced after write");

        // R3 R5 read without increment
        set_addr(5);
        host_wr(2'd2, 8'h00);
        host_rd(2'd3, 8'hA1, "R3 data read returns RAM byte");
        host_rd(2'd0, 8'h05, "R5 no advance when disabled");

        // R4 write enable does not affect reads
        host_wr(2'd2, 8'h80);
        host_rd(2'd3, 8'hA1, "R4 read with write-only enable");
        host_rd(2'd0, 8'h05, "R4 write enable ignored on read");
        host_wr(2'd2, 8'h40);
        host_rd(2'd3, 8'hA1, "R4 read with read enable");
        host_rd(2'd0, 8'h06, "R4 read enable advances");

        // R6 R7 connection memory fill with increment on write
        set_addr(0);
        host_wr(2'd2, 8'h81);
        host_wr(2'd3, 8'h11);
        host_rd(2'd2, 8'h82, "R6 lane low to high");
        host_rd(2'd0, 8'h00, "R6 address kept after low byte");
        host_wr(2'd3, 8'h22);
        host_rd(2'd2, 8'h81, "R7 lane high back to low");
        host_rd(2'd0, 8'h01, "R7 address advanced after high byte");
        host_wr(2'd3, 8'h33);
        host_wr(2'd3, 8'h44);
        host_rd(2'd0, 8'h02, "R7 address after two pairs");
        chk(m_lo[0] == 8'h11 && m_hi[0] == 8'h22, "R6 pair 0 stored", {m_hi[0], m_lo[0]}, 16'h2211);
        chk(m_lo[1] == 8'h33 && m_hi[1] == 8'h44, "R7 pair 1 stored", {m_hi[1], m_lo[1]}, 16'h4433);

        // R6 R7 connection memory without increment
        set_addr(0);
        host_wr(2'd2, 8'h01);
        host_rd(2'd3, 8'h11, "R6 low byte read");
        host_rd(2'd2, 8'h02, "R6 flip once without enable");
        host_rd(2'd3, 8'h22, "R7 high byte read");
        host_rd(2'd2, 8'h02, "R7 lane held without enable");
        host_rd(2'd0, 8'h00, "R7 address held without enable");

        // R6 R7 streaming read back
        set_addr(0);
        host_wr(2'd2, 8'h41);
        host_rd(2'd3, 8'h11, "R6 stream read 0 low");
        host_rd(2'd3, 8'h22, "R7 stream read 0 high");
        host_rd(2'd3, 8'h33, "R6 stream read 1 low");
        host_rd(2'd3, 8'h44, "R7 stream read 1 high");
        host_rd(2'd0, 8'h02, "R7 address after stream read");

        // R8 space encoding
        host_wr(2'd2, 8'h03);
        host_rd(2'd2, 8'h00, "R8 code 3 maps to sample");
        host_wr(2'd2, 8'h02);
        host_rd(2'd2, 8'h02, "R8 code 2 selects high lane");

        // R9 R10 out of range
        set_addr(400);
        host_rd(2'd1, 8'h01, "R2 address high bit readback");
        host_wr(2'd2, 8'hC0);
        w0 = rd_cnt;
        host_rd(2'd3, 8'h00, "R9 out-of-range read gives zero");
        chk(rd_cnt == w0, "R9 no ram_rd out of range", rd_cnt - w0, 0);
        host_rd(2'd0, 8'h00, "R10 advance from above last wraps");
        set_addr(400);
        w0 = wr_cnt;
        host_wr(2'd3, 8'h55);
        chk(wr_cnt == w0, "R9 no ram_wr out of range", wr_cnt - w0, 0);

        // R10 wrap and lane flip together
        set_addr(383);
        host_wr(2'd2, 8'h82);
        host_wr(2'd3, 8'h77);
        chk(m_hi[383] == 8'h77, "R10 high byte at 383", m_hi[383], 8'h77);
        host_rd(2'd0, 8'h00, "R10 wrap low address");
        host_rd(2'd1, 8'h00, "R10 wrap high address");
        host_rd(2'd2, 8'h81, "R10 lane back to low on wrap");

        // R11 strobe while busy
        host_wr(2'd2, 8'h00);
        set_addr(10);
        w0 = wr_cnt;
        h_reg = 2'd3; h_wdata = 8'h99; h_wr = 1'b1;
        @(negedge clk);
        h_reg = 2'd0; h_wdata = 8'hEE;
        @(negedge clk);
        h_wr = 1'b0;
        wait_idle();
        host_rd(2'd0, 8'h0A, "R11 address write while busy ignored");
        chk(m_samp[10] == 8'h99, "R11 data write completed", m_samp[10], 8'h99);
        chk(wr_cnt == w0 + 1, "R11 single ram_wr", wr_cnt - w0, 1);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule